// File: doc/BRIEF.md
# Switch Allocation-Interface Serializer

This block sits on a function card and handles that card's side of the narrow control link to a crossbar switch allocator. An epoch is eight ticks of the allocation clock. In each epoch the block shifts out two 15-bit masks, two bits per tick. One mask names the destination cards this card wants to send to. The other names the source cards this card will accept data from.

The block also reads two serial status pins. Each pin carries a 4-bit partner number in the first four ticks of an epoch. The value received in one epoch (the notify epoch) is held on the partner outputs for the whole of the next epoch, which is the transfer epoch. The card's data path uses these outputs to know whom it drives to and whom it captures from.

A transfer always moves a pair of 64-byte slots. A destination with only one unit queued is not requested at once: it is held back for a configurable number of epochs so that a second unit has time to arrive. A destination with two or more units is requested in the very next epoch.

Top module: `alloc_if_serdes`

## Requirements
- R1: `tickIdx` is 0 in the first cycle after reset and counts 0..7, wrapping from 7 to 0. `epochStart` is high exactly when `tickIdx` is 0.
- R2: The request mask taken at an epoch boundary (the clock edge that ends tick 7) is sent during the epoch that follows. Mask bit i appears on `reqPins[i%2]` during tick i/2, and the unused sixteenth slot (`reqPins[1]` in tick 7) is 0.
- R3: `permitMask` is sampled at the same boundary and sent on `permitPins` with the same bit placement, including the zero in the sixteenth slot.
- R4: A destination whose `pendTwo` bit is 1 at a boundary has its request bit set in the epoch that follows.
- R5: A destination with only `pendOne` set is requested only when it has had `pendOne` set and `pendTwo` clear at PAIR_WAIT (default 3) earlier consecutive boundaries. Any boundary at which that condition fails restarts the count.
- R6: Each status pin is read least significant bit first, one bit per tick, in ticks 0 to 3. The resulting number appears on the matching partner output from tick 0 of the next epoch and stays constant through tick 7. `sendStatusPin` feeds `sendPartner`; `recvStatusPin` feeds `recvPartner`.
- R7: A received number of 15 means no connection, and the matching valid output is then low. Values 0 to 14 set it high. Bits on the status pins during ticks 4 to 7 have no effect.
- R8: During and right after reset, all four mask pins are 0 and both valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Allocation clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pendOne | input | 15 | Per destination: exactly one unit queued |
| pendTwo | input | 15 | Per destination: two or more units queued |
| permitMask | input | 15 | Per source: 1 allows that source to send here |
| sendStatusPin | input | 1 | Serial number of the card to send to |
| recvStatusPin | input | 1 | Serial number of the card to receive from |
| reqPins | output | 2 | Serialized destination request mask |
| permitPins | output | 2 | Serialized source permission mask |
| epochStart | output | 1 | High in tick 0 of each epoch |
| tickIdx | output | 3 | Tick position within the epoch |
| sendValid | output | 1 | A send partner is granted this epoch |
| sendPartner | output | 4 | Card to send to this epoch |
| recvValid | output | 1 | A receive partner is granted this epoch |
| recvPartner | output | 4 | Card to receive from this epoch |

## Verification
Queue state and the permission mask are applied in tick 7, so they are taken at the edge that closes the epoch. Their bits then show on the pins over all eight ticks of the following epoch. The bench rebuilds both 16-bit words from reads taken at the falling edge of each tick before comparing them.

A status bit driven at the falling edge in tick k is captured at the rising edge that ends tick k. The partner it forms belongs to the next epoch, so the bench checks the partner outputs in tick 0 and again in tick 7 of that later epoch. Expected request bits come from a count of queue boundaries kept in the bench. Fixed destinations give known answers: a lone unit that is requested first in the fourth epoch, a toggling single unit that is never requested, and a double-queued destination that is requested every third epoch.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  localparam int unsigned CARD_COUNT  = 15;
  localparam int unsigned EPOCH_TICKS = 8;
  localparam int unsigned PARTNER_W   = 4;

  typedef struct packed {
    logic epochEnd;  // last tick: masks load, partners advance
    logic capture;   // status bit slot of the current tick
  } strobe_t;
endpackage

// File: rtl/alloc_ctrl.sv
module alloc_ctrl
  import alloc_pkg::*;
#(
  parameter int unsigned TICKS = EPOCH_TICKS,
  parameter int unsigned ID_W  = PARTNER_W,
  localparam int unsigned TICK_W = $clog2(TICKS)
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [TICK_W-1:0] tickIdx,
  output logic              epochStart,
  output strobe_t           stb
);
  localparam logic [TICK_W-1:0] LAST = TICK_W'(TICKS - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickIdx <= '0;
    else if (tickIdx == LAST) tickIdx <= '0;
    else tickIdx <= tickIdx + 1'b1;
  end

  assign epochStart   = (tickIdx == '0);
  assign stb.epochEnd = (tickIdx == LAST);
  assign stb.capture  = (int'(tickIdx) < int'(ID_W));

  assert_tick_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (tickIdx != LAST) |=> (tickIdx == $past(tickIdx) + 1'b1));
  assert_tick_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (tickIdx == LAST) |=> (tickIdx == '0));
endmodule

// File: rtl/alloc_pair_gate.sv
module alloc_pair_gate #(
  parameter int unsigned CARDS     = 15,
  parameter int unsigned PAIR_WAIT = 3,
  localparam int unsigned CW = $clog2(PAIR_WAIT + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             epochEnd,
  input  logic [CARDS-1:0] pendOne,
  input  logic [CARDS-1:0] pendTwo,
  output logic [CARDS-1:0] reqMask
);
  localparam logic [CW-1:0] WAIT_MAX = CW'(PAIR_WAIT);

  logic [CARDS-1:0][CW-1:0] waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (epochEnd) begin
      for (int d = 0; d < int'(CARDS); d++) begin
        if (pendOne[d] && !pendTwo[d])
          waitCnt[d] <= (waitCnt[d] == WAIT_MAX) ? waitCnt[d] : waitCnt[d] + 1'b1;
        else
          waitCnt[d] <= '0;
      end
    end
  end

  for (genvar d = 0; d < int'(CARDS); d++) begin : gDest
    assign reqMask[d] = pendTwo[d] | (pendOne[d] & (waitCnt[d] == WAIT_MAX));

    assert_wait_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
      waitCnt[d] <= WAIT_MAX);
    assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      !epochEnd |=> $stable(waitCnt[d]));
  end
endmodule

// File: rtl/alloc_dp.sv
module alloc_dp
  import alloc_pkg::*;
#(
  parameter int unsigned CARDS = 15,
  parameter int unsigned TICKS = 8,
  parameter int unsigned ID_W  = 4,
  localparam int unsigned SLOTS = 2 * TICKS
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [CARDS-1:0] reqMask,
  input  logic [CARDS-1:0] permitMask,
  input  logic             sendStatusPin,
  input  logic             recvStatusPin,
  output logic [1:0]       reqPins,
  output logic [1:0]       permitPins,
  output logic             sendValid,
  output logic [ID_W-1:0]  sendPartner,
  output logic             recvValid,
  output logic [ID_W-1:0]  recvPartner
);
  localparam logic [ID_W-1:0] NONE = '1;

  logic [SLOTS-1:0] reqSh, permSh;
  logic [1:0]            statusPin;
  logic [1:0][ID_W-1:0]  shIn, part;
  logic [1:0]            vld;

  // mask serializers: two bits per tick, low bits first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqSh  <= '0;
      permSh <= '0;
    end else if (stb.epochEnd) begin
      reqSh  <= SLOTS'(reqMask);
      permSh <= SLOTS'(permitMask);
    end else begin
      reqSh  <= reqSh >> 2;
      permSh <= permSh >> 2;
    end
  end

  assign reqPins    = reqSh[1:0];
  assign permitPins = permSh[1:0];

  // partner deserializers: lane 0 send, lane 1 receive
  assign statusPin = {recvStatusPin, sendStatusPin};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shIn <= '1;
      part <= '1;
      vld  <= '0;
    end else begin
      for (int g = 0; g < 2; g++) begin
        if (stb.capture) shIn[g] <= {statusPin[g], shIn[g][ID_W-1:1]};
        if (stb.epochEnd) begin
          part[g] <= shIn[g];
          vld[g]  <= (shIn[g] != NONE);
        end
      end
    end
  end

  assign sendPartner = part[0];
  assign sendValid   = vld[0];
  assign recvPartner = part[1];
  assign recvValid   = vld[1];

  for (genvar g = 0; g < 2; g++) begin : gLane
    assert_hold_partner_R6: assert property (@(posedge clk) disable iff (!rstN)
      !$past(stb.epochEnd) |-> ($stable(part[g]) && $stable(vld[g])));
    assert_none_code_R7: assert property (@(posedge clk) disable iff (!rstN)
      vld[g] |-> (part[g] != NONE));
  end

  if (SLOTS - 1 >= CARDS) begin : gPad
    assert_pad_slot_R2: assert property (@(posedge clk) disable iff (!rstN)
      stb.epochEnd |-> (reqPins[1] == 1'b0 && permitPins[1] == 1'b0));
  end
endmodule

// File: rtl/alloc_if_serdes.sv
module alloc_if_serdes
  import alloc_pkg::*;
#(
  parameter int unsigned CARDS     = CARD_COUNT,
  parameter int unsigned TICKS     = EPOCH_TICKS,
  parameter int unsigned ID_W      = PARTNER_W,
  parameter int unsigned PAIR_WAIT = 3,
  localparam int unsigned TICK_W = $clog2(TICKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CARDS-1:0]  pendOne,
  input  logic [CARDS-1:0]  pendTwo,
  input  logic [CARDS-1:0]  permitMask,
  input  logic              sendStatusPin,
  input  logic              recvStatusPin,
  output logic [1:0]        reqPins,
  output logic [1:0]        permitPins,
  output logic              epochStart,
  output logic [TICK_W-1:0] tickIdx,
  output logic              sendValid,
  output logic [ID_W-1:0]   sendPartner,
  output logic              recvValid,
  output logic [ID_W-1:0]   recvPartner
);
  strobe_t          stb;
  logic [CARDS-1:0] reqMask;

  alloc_ctrl #(.TICKS(TICKS), .ID_W(ID_W)) uCtrl (
    .clk(clk), .rstN(rstN), .tickIdx(tickIdx), .epochStart(epochStart), .stb(stb)
  );

  alloc_pair_gate #(.CARDS(CARDS), .PAIR_WAIT(PAIR_WAIT)) uGate (
    .clk(clk), .rstN(rstN), .epochEnd(stb.epochEnd),
    .pendOne(pendOne), .pendTwo(pendTwo), .reqMask(reqMask)
  );

  alloc_dp #(.CARDS(CARDS), .TICKS(TICKS), .ID_W(ID_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqMask(reqMask), .permitMask(permitMask),
    .sendStatusPin(sendStatusPin), .recvStatusPin(recvStatusPin),
    .reqPins(reqPins), .permitPins(permitPins),
    .sendValid(sendValid), .sendPartner(sendPartner),
    .recvValid(recvValid), .recvPartner(recvPartner)
  );
endmodule

// File: tb/sim_alloc_if_serdes.sv
module sim_alloc_if_serdes;
  localparam int W = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] pendOne = '0, pendTwo = '0, permitMask = '0;
  logic        sendStatusPin = 1'b1, recvStatusPin = 1'b1;
  logic [1:0]  reqPins, permitPins;
  logic        epochStart, sendValid, recvValid;
  logic [2:0]  tickIdx;
  logic [3:0]  sendPartner, recvPartner;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  int cntModel [15];
  logic [3:0] prevS = 4'hF, prevR = 4'hF;
  logic [31:0] rng = 32'h1234_5679;

  always #10 clk = ~clk;

  alloc_if_serdes u0 (
    .clk(clk), .rstN(rstN), .pendOne(pendOne), .pendTwo(pendTwo),
    .permitMask(permitMask), .sendStatusPin(sendStatusPin), .recvStatusPin(recvStatusPin),
    .reqPins(reqPins), .permitPins(permitPins), .epochStart(epochStart), .tickIdx(tickIdx),
    .sendValid(sendValid), .sendPartner(sendPartner),
    .recvValid(recvValid), .recvPartner(recvPartner)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic checkPartners();
    chk("R6 R7 sendValid", 32'(sendValid), 32'(prevS != 4'hF));
    if (prevS != 4'hF) chk("R6 sendPartner", 32'(sendPartner), 32'(prevS));
    chk("R6 R7 recvValid", 32'(recvValid), 32'(prevR != 4'hF));
    if (prevR != 4'hF) chk("R6 recvPartner", 32'(recvPartner), 32'(prevR));
  endtask

  // entry and exit: falling edge in tick 7
  task automatic doEpoch(input int e, input logic [14:0] one, input logic [14:0] two,
                         input logic [14:0] perm, input logic [3:0] sCode,
                         input logic [3:0] rCode);
    logic [15:0] expReq, gotReq, gotPerm;
    pendOne = one; pendTwo = two; permitMask = perm;
    expReq = '0;
    for (int d = 0; d < 15; d++) begin
      expReq[d] = two[d] | (one[d] && cntModel[d] >= W);
      if (one[d] && !two[d]) cntModel[d] = (cntModel[d] >= W) ? W : cntModel[d] + 1;
      else cntModel[d] = 0;
    end
    gotReq = '0; gotPerm = '0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == 0) begin
        chk("R1 tickIdx at start", 32'(tickIdx), 0);
        chk("R1 epochStart", 32'(epochStart), 1);
        checkPartners();
      end
      if (k == 5) chk("R1 epochStart low", 32'(epochStart), 0);
      gotReq[2*k]    = reqPins[0];
      gotReq[2*k+1]  = reqPins[1];
      gotPerm[2*k]   = permitPins[0];
      gotPerm[2*k+1] = permitPins[1];
      if (k < 4) begin
        sendStatusPin = sCode[k];
        recvStatusPin = rCode[k];
      end else begin
        sendStatusPin = ~sCode[k-4];
        recvStatusPin = ~rCode[k-4];
      end
      if (k == 7) checkPartners();
    end
    chk("R2 R4 R5 request word", 32'(gotReq), 32'(expReq));
    chk("R2 pad slot", 32'(gotReq[15]), 0);
    chk("R3 permit word", 32'(gotPerm), 32'({1'b0, perm}));
    chk("R5 lone unit dest0", 32'(gotReq[0]), 32'(e >= W));
    chk("R5 toggling lone unit dest4", 32'(gotReq[4]), 0);
    chk("R4 double unit dest1", 32'(gotReq[1]), 32'(e % 3 == 0));
    prevS = sCode; prevR = rCode;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < 15; d++) cntModel[d] = 0;
    repeat (3) @(negedge clk);
    chk("R8 reqPins in reset", 32'(reqPins), 0);
    chk("R8 permitPins in reset", 32'(permitPins), 0);
    chk("R8 sendValid in reset", 32'(sendValid), 0);
    chk("R8 recvValid in reset", 32'(recvValid), 0);
    rstN = 1'b1;
    chk("R1 tick after reset", 32'(tickIdx), 0);
    @(posedge clk); @(negedge clk);
    chk("R8 reqPins after reset", 32'(reqPins), 0);
    chk("R8 valid after reset", 32'({sendValid, recvValid}), 0);
    chk("R1 tick one", 32'(tickIdx), 1);
    repeat (6) @(negedge clk);
    chk("R1 tick seven", 32'(tickIdx), 7);
    for (int e = 0; e < 34; e++) begin
      logic [14:0] one, two, perm;
      rng = nextRng(rng);
      one  = {rng[9:0], 1'(e % 2), 4'b0101};
      two  = {rng[24:15], 3'b000, 1'(e % 3 == 0), 1'b0};
      rng = nextRng(rng);
      perm = (e == 5) ? 15'h7FFF : rng[14:0];
      doEpoch(e, one, two, perm, 4'(e), 4'(15 - e));
    end
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule